// File: doc/BRIEF.md
# Serial Register Access Port

This block is a four-wire serial slave. A host uses it to read and write a small set of 8-bit configuration and status registers. The pins are a select, a serial clock, serial data in and serial data out. Serial data out is brought out as a data bit plus an output-enable that drives the pad's tri-state buffer. Every frame is sixteen serial clocks long. The first byte is a command and the second byte is the data. The command holds a direction flag, a sub-address and a port address. Port address 0 selects a global bank of eight registers. Port address 1 selects a port bank of eight registers. Any larger port address makes the frame a silent no-op.

The serial inputs are oversampled on the chip's system clock through a synchronizer, and the clock edges are found there. Every register update therefore happens in the system clock domain. This is the same domain in which hardware status events arrive. The bank holds three kinds of register. Some fields are loaded from strap pins at hardware reset. One status register has sticky bits that a completed read clears. One control bit causes a soft reset and reads back as zero. All register contents are also presented in parallel to the rest of the chip.

Top module: `sra_port`

## Requirements
- R1: While `sen` is low, activity on `sclk` and `sdi` changes no register, and `sdo_oe` stays low.
- R2: `sdi` is taken on rising `sclk` edges. Read data changes only after falling `sclk` edges, so the host can sample it just before the next rising edge.
- R3: The first eight bits form the command and arrive least significant bit first. Bit 0 is the direction (1 = read, 0 = write), bits 3:1 are the sub-address and bits 7:4 are the port address.
- R4: The eight data bits that follow the command are least significant bit first, for both writes and reads.
- R5: `sdo_oe` is high only while the eight read-data bits of a valid read are presented. It is low during the command and after the last data bit.
- R6: Port address 0 selects the global bank and port address 1 selects the port bank. For a port address of 2 or more, a write changes nothing and a read never raises `sdo_oe`.
- R7: Writing global register 0 with bit 0 set returns every register, the status register included, to its default value and discards the rest of that written byte. Bit 0 always reads back as 0.
- R8: Bits 4:3 of global register 0 (reference clock select) and bits 4:3 of port register 0 (transmit timing mode) take their defaults from `strap_refclk` and `strap_txmode` as sampled during hardware reset. A soft reset restores those same sampled values, not the current pin levels. The other defaults are: global register 1 = 0x27, port register 0 low bits = 0x01, port register 3 = 0xA8, port register 4 = 0x80, and 0 everywhere else.
- R9: Port register 5 is status. A pulse on `stat_evt` bit 4, bit 1 or bit 0 sets the same bit of that register, and the bit stays set. The other event bits are ignored. A completed read of the register clears exactly the bits it returned.
- R10: If a status event arrives in the same cycle as the clearing read completes, the status bit stays set.
- R11: A frame that ends (with `sen` low) before its sixteenth rising clock edge leaves every register unchanged. This includes a status read that is cut short.
- R12: Writes to the status register and to port registers 6 and 7 are ignored; registers 6 and 7 read as 0. `cfg_global` and `cfg_port` present register n on bits 8n+7:8n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| sen | input | 1 | Serial select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data, 0 while not enabled |
| sdo_oe | output | 1 | Output enable for the serial data-out pad driver |
| strap_refclk | input | 2 | Strap value for the reference clock select field |
| strap_txmode | input | 2 | Strap value for the transmit timing mode field |
| stat_evt | input | 8 | Single-cycle hardware status event pulses |
| cfg_global | output | 64 | Parallel view of the global bank |
| cfg_port | output | 64 | Parallel view of the port bank, including status |

## Verification
Two actions can hit the same status bit in the same system clock cycle: a hardware event setting it, and the completion of a read that clears it. The bench counts the synchronizer and edge-detect stages from the sixteenth rising `sclk` edge. It pulses the event for exactly the one cycle in which the clear takes effect. A correct design still shows the bit set, both on `cfg_port` and in the next serial read. If the clear wins the collision, the bit comes back as 0. A second collision pairs a soft-reset write with a coinciding event, and the event must again survive.

// File: rtl/sra_pkg.sv
package sra_pkg;
    // Bank selection by port address
    localparam int PA_GLOBAL   = 0;
    localparam int PA_PORT     = 1;
    // Sub-addresses with special behaviour
    localparam int SA_CTRL     = 0;
    localparam int SA_STATUS   = 5;
    localparam int SA_RO_FIRST = 6;
    // Bit positions decoded by neighbouring logic
    localparam int SRST_BIT    = 0;
    localparam int STRAP_LSB   = 3;
    localparam int STRAP_W     = 2;
endpackage

// File: rtl/sra_sync.sv
module sra_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/sra_frame.sv
module sra_frame import sra_pkg::*; #(
    parameter int DW   = 8,
    parameter int SA_W = 3,
    parameter int PA_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sen_s,
    input  logic            sclk_s,
    input  logic            sdi_s,
    input  logic [DW-1:0]   rd_byte,
    output logic [PA_W-1:0] acc_pa,
    output logic [SA_W-1:0] acc_sa,
    output logic [DW-1:0]   acc_wdata,
    output logic            wr_stb,
    output logic            rd_done_stb,
    output logic [DW-1:0]   rd_mask,
    output logic            sdo,
    output logic            sdo_oe
);
    localparam int CMD_W      = 1 + SA_W + PA_W;
    localparam int FRAME_BITS = CMD_W + DW;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] CMD_END  = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] FRM_END  = CNT_W'(FRAME_BITS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk_prev;
        logic [CMD_W-1:0] cmd;
        logic [DW-2:0]    dat;
        logic [DW-1:0]    shreg;
        logic [DW-1:0]    snap;
        logic             rd_act;
        logic             sdo;
        logic             oe;
    } frm_t;

    frm_t frm_d, frm_q;
    logic             rise, fall, is_rd, addr_ok, rd_cap;
    logic [CMD_W-1:0] cmd_now;

    always_comb begin
        frm_d = frm_q;
        rise  = sen_s &  sclk_s & ~frm_q.sclk_prev;
        fall  = sen_s & ~sclk_s &  frm_q.sclk_prev;

        // The command is decoded in the same cycle as its last bit arrives
        cmd_now   = (frm_q.cnt == CMD_LAST) ? {sdi_s, frm_q.cmd[CMD_W-1:1]} : frm_q.cmd;
        is_rd     = cmd_now[0];
        acc_sa    = cmd_now[SA_W:1];
        acc_pa    = cmd_now[CMD_W-1:SA_W+1];
        addr_ok   = acc_pa <= PA_W'(PA_PORT);
        acc_wdata = {sdi_s, frm_q.dat};

        rd_cap      = rise && (frm_q.cnt == CMD_LAST) && is_rd && addr_ok;
        wr_stb      = rise && (frm_q.cnt == FRM_LAST) && !frm_q.cmd[0] && addr_ok;
        rd_done_stb = rise && (frm_q.cnt == FRM_LAST) && frm_q.rd_act;
        rd_mask     = frm_q.snap;

        frm_d.sclk_prev = sclk_s;

        if (!sen_s) begin
            frm_d.cnt    = '0;
            frm_d.rd_act = 1'b0;
            frm_d.oe     = 1'b0;
            frm_d.sdo    = 1'b0;
        end else begin
            if (rise) begin
                if (frm_q.cnt < CMD_END) begin
                    frm_d.cmd = {sdi_s, frm_q.cmd[CMD_W-1:1]};
                end else if (frm_q.cnt < FRM_END) begin
                    frm_d.dat = acc_wdata[DW-1:1];
                end
                if (frm_q.cnt < FRM_END) frm_d.cnt = frm_q.cnt + 1'b1;
                if (rd_cap) begin
                    frm_d.shreg  = rd_byte;
                    frm_d.snap   = rd_byte;
                    frm_d.rd_act = 1'b1;
                end
            end
            if (fall) begin
                if (frm_q.rd_act && frm_q.cnt >= CMD_END && frm_q.cnt < FRM_END) begin
                    frm_d.sdo   = frm_q.shreg[0];
                    frm_d.shreg = frm_q.shreg >> 1;
                    frm_d.oe    = 1'b1;
                end else begin
                    frm_d.sdo = 1'b0;
                    frm_d.oe  = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) frm_q <= '0;
        else        frm_q <= frm_d;
    end

    assign sdo    = frm_q.sdo;
    assign sdo_oe = frm_q.oe;
endmodule

// File: rtl/sra_regs.sv
module sra_regs import sra_pkg::*; #(
    parameter int                 DW        = 8,
    parameter int                 NREG      = 8,
    parameter int                 PA_W      = 4,
    parameter logic [NREG*DW-1:0] GLB_RST   = '0,
    parameter logic [NREG*DW-1:0] PRT_RST   = '0,
    parameter logic [DW-1:0]      STAT_MASK = '1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [STRAP_W-1:0]          strap_refclk,
    input  logic [STRAP_W-1:0]          strap_txmode,
    input  logic [DW-1:0]               stat_evt,
    input  logic [PA_W-1:0]             acc_pa,
    input  logic [$clog2(NREG)-1:0]     acc_sa,
    input  logic [DW-1:0]               acc_wdata,
    input  logic                        wr_stb,
    input  logic                        rd_done_stb,
    input  logic [DW-1:0]               rd_mask,
    output logic [DW-1:0]               rd_byte,
    output logic [NREG*DW-1:0]          cfg_global,
    output logic [NREG*DW-1:0]          cfg_port
);
    localparam int SA_W = $clog2(NREG);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] glb;
        logic [NREG-1:0][DW-1:0] prt;
        logic [STRAP_W-1:0]      rc;
        logic [STRAP_W-1:0]      tm;
    } rf_t;

    rf_t rf_d, rf_q, rf_init;
    logic is_glb, is_prt, srst, prt_wr_ok, is_stat;

    function automatic rf_t dflt(input logic [STRAP_W-1:0] rc, input logic [STRAP_W-1:0] tm);
        rf_t v;
        v.glb = GLB_RST;
        v.prt = PRT_RST;
        v.glb[SA_CTRL][STRAP_LSB +: STRAP_W] = rc;
        v.prt[SA_CTRL][STRAP_LSB +: STRAP_W] = tm;
        v.glb[SA_CTRL][SRST_BIT]             = 1'b0;
        v.prt[SA_STATUS]                     = '0;
        for (int i = SA_RO_FIRST; i < NREG; i++) v.prt[i] = '0;
        v.rc = rc;
        v.tm = tm;
        return v;
    endfunction

    always_comb begin
        rf_init   = dflt(strap_refclk, strap_txmode);
        rf_d      = rf_q;
        is_glb    = acc_pa == PA_W'(PA_GLOBAL);
        is_prt    = acc_pa == PA_W'(PA_PORT);
        is_stat   = acc_sa == SA_W'(SA_STATUS);
        prt_wr_ok = !is_stat && (acc_sa < SA_W'(SA_RO_FIRST));
        srst      = wr_stb && is_glb && (acc_sa == SA_W'(SA_CTRL)) && acc_wdata[SRST_BIT];

        if (wr_stb && is_glb) begin
            rf_d.glb[acc_sa] = acc_wdata;
            rf_d.glb[SA_CTRL][SRST_BIT] = 1'b0;
        end
        if (wr_stb && is_prt && prt_wr_ok) rf_d.prt[acc_sa] = acc_wdata;

        // Only the bits the host actually saw are cleared
        if (rd_done_stb && is_prt && is_stat) begin
            rf_d.prt[SA_STATUS] = rf_q.prt[SA_STATUS] & ~rd_mask;
        end

        if (srst) rf_d = dflt(rf_q.rc, rf_q.tm);

        // Events are merged last so they win over any clear
        rf_d.prt[SA_STATUS] = rf_d.prt[SA_STATUS] | (stat_evt & STAT_MASK);

        if (is_glb)      rd_byte = rf_q.glb[acc_sa];
        else if (is_prt) rd_byte = rf_q.prt[acc_sa];
        else             rd_byte = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= rf_init;
        else        rf_q <= rf_d;
    end

    assign cfg_global = rf_q.glb;
    assign cfg_port   = rf_q.prt;
endmodule

// File: rtl/sra_port.sv
module sra_port import sra_pkg::*; #(
    parameter int                 DW          = 8,
    parameter int                 NREG        = 8,
    parameter int                 PA_W        = 4,
    parameter int                 SYNC_STAGES = 2,
    parameter logic [NREG*DW-1:0] GLB_RST     = 64'h0000_0000_0000_2700,
    parameter logic [NREG*DW-1:0] PRT_RST     = 64'h0000_0080_A800_0001,
    parameter logic [DW-1:0]      STAT_MASK   = 8'h13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sen,
    input  logic               sclk,
    input  logic               sdi,
    output logic               sdo,
    output logic               sdo_oe,
    input  logic [1:0]         strap_refclk,
    input  logic [1:0]         strap_txmode,
    input  logic [7:0]         stat_evt,
    output logic [63:0]        cfg_global,
    output logic [63:0]        cfg_port
);
    localparam int SA_W = $clog2(NREG);

    logic [2:0]      pins_s;
    logic [PA_W-1:0] acc_pa;
    logic [SA_W-1:0] acc_sa;
    logic [DW-1:0]   acc_wdata, rd_byte, rd_mask;
    logic            wr_stb, rd_done_stb;

    sra_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sen, sclk, sdi}),
        .q     (pins_s)
    );

    sra_frame #(.DW(DW), .SA_W(SA_W), .PA_W(PA_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sen_s       (pins_s[2]),
        .sclk_s      (pins_s[1]),
        .sdi_s       (pins_s[0]),
        .rd_byte     (rd_byte),
        .acc_pa      (acc_pa),
        .acc_sa      (acc_sa),
        .acc_wdata   (acc_wdata),
        .wr_stb      (wr_stb),
        .rd_done_stb (rd_done_stb),
        .rd_mask     (rd_mask),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe)
    );

    sra_regs #(
        .DW(DW), .NREG(NREG), .PA_W(PA_W),
        .GLB_RST(GLB_RST), .PRT_RST(PRT_RST), .STAT_MASK(STAT_MASK)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_refclk (strap_refclk),
        .strap_txmode (strap_txmode),
        .stat_evt     (stat_evt),
        .acc_pa       (acc_pa),
        .acc_sa       (acc_sa),
        .acc_wdata    (acc_wdata),
        .wr_stb       (wr_stb),
        .rd_done_stb  (rd_done_stb),
        .rd_mask      (rd_mask),
        .rd_byte      (rd_byte),
        .cfg_global   (cfg_global),
        .cfg_port     (cfg_port)
    );
endmodule

// File: rtl/sra_port_chk.sv
module sra_port_chk #(
    parameter logic [63:0] GLB_RST   = '0,
    parameter logic [7:0]  STAT_MASK = '1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        sen,
    input logic        sclk,
    input logic        sdo,
    input logic        sdo_oe,
    input logic [7:0]  stat_evt,
    input logic [63:0] cfg_global,
    input logic [63:0] cfg_port,
    input logic        wr_stb,
    input logic        rd_done_stb,
    input logic [3:0]  acc_pa,
    input logic [2:0]  acc_sa,
    input logic [7:0]  acc_wdata
);
    logic srst_wr;
    assign srst_wr = wr_stb && acc_pa == 4'd0 && acc_sa == 3'd0 && acc_wdata[0];

    AST_OE_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!sen && !$past(sen) && !$past(sen, 2) && !$past(sen, 3)) |-> !sdo_oe); // R1

    AST_SDO_MOVES_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && sdo != $past(sdo)) |-> !$past(sclk)); // R2

    AST_STROBE_VALID_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || rd_done_stb) |-> acc_pa <= 4'd1); // R6

    AST_SRST_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        srst_wr |=> (cfg_global[63:8] == GLB_RST[63:8]) && !cfg_global[0]); // R7

    AST_STATUS_FALL_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cfg_port[47:40]) & ~cfg_port[47:40]) != 8'h00) |-> $past(rd_done_stb || srst_wr)); // R9

    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_evt & STAT_MASK) != 8'h00) |=>
        ((cfg_port[47:40] & $past(stat_evt & STAT_MASK)) == $past(stat_evt & STAT_MASK))); // R10

    AST_GLOBAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(cfg_global)); // R11

    AST_PORT_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(cfg_port[39:0])); // R11
endmodule

bind sra_port sra_port_chk #(.GLB_RST(GLB_RST), .STAT_MASK(STAT_MASK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sen         (sen),
    .sclk        (sclk),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe),
    .stat_evt    (stat_evt),
    .cfg_global  (cfg_global),
    .cfg_port    (cfg_port),
    .wr_stb      (wr_stb),
    .rd_done_stb (rd_done_stb),
    .acc_pa      (acc_pa),
    .acc_sa      (acc_sa),
    .acc_wdata   (acc_wdata)
);

// File: tb/tb_sra_port.sv
module tb_sra_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sen = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic        sdo, sdo_oe;
    logic [1:0]  strap_refclk = 2'b10, strap_txmode = 2'b01;
    logic [7:0]  stat_evt = 8'h00;
    logic [63:0] cfg_global, cfg_port;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [7:0] rd;
    logic       oe_ok;

    sra_port dut (
        .clk(clk), .rst_n(rst_n), .sen(sen), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .strap_refclk(strap_refclk),
        .strap_txmode(strap_txmode), .stat_evt(stat_evt),
        .cfg_global(cfg_global), .cfg_port(cfg_port)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] mk(input logic rw, input logic [3:0] pa, input logic [2:0] sa);
        return {pa, sa, rw};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial frame of nbits clocks; coll_evt is pulsed in the cycle the last rising edge takes effect
    task automatic xfer(input logic [7:0] cmd, input logic [7:0] wd, input int nbits,
                        input logic [7:0] coll_evt, output logic [7:0] rdat, output logic oe_good);
        logic exp_rd;
        exp_rd  = cmd[0] && (cmd[7:4] <= 4'd1);
        rdat    = 8'h00;
        oe_good = 1'b1;
        @(negedge clk) sen = 1'b1;
        idle(HALF);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 8) ? cmd[i] : wd[i-8];
            idle(HALF);
            if (i >= 8) rdat[i-8] = sdo;
            if (sdo_oe !== (exp_rd && i >= 8)) oe_good = 1'b0;
            sclk = 1'b1;
            for (int j = 0; j < HALF; j++) begin
                @(negedge clk);
                if (i == 15 && j == 1) stat_evt = coll_evt;
                if (i == 15 && j == 2) stat_evt = 8'h00;
            end
            sclk = 1'b0;
        end
        idle(HALF);
        if (nbits >= 16 && sdo_oe !== 1'b0) oe_good = 1'b0;
        sen = 1'b0;
        sdi = 1'b0;
        idle(2 * HALF);
        if (sdo_oe !== 1'b0) oe_good = 1'b0;
    endtask

    task automatic wr(input logic [3:0] pa, input logic [2:0] sa, input logic [7:0] d);
        logic [7:0] r;
        logic       o;
        xfer(mk(1'b0, pa, sa), d, 16, 8'h00, r, o);
    endtask

    task automatic pulse_evt(input logic [7:0] e);
        @(negedge clk) stat_evt = e;
        @(negedge clk) stat_evt = 8'h00;
        idle(1);
    endtask

    task automatic test_reset;
        chk("R8 refclk strap default", cfg_global[7:0], 8'h10);
        chk("R8 global reg1 default", cfg_global[15:8], 8'h27);
        chk("R8 txmode strap default", cfg_port[7:0], 8'h09);
        chk("R8 port reg3 default", cfg_port[31:24], 8'hA8);
        chk("R9 status clear at reset", cfg_port[47:40], 8'h00);
        chk("R5 oe low at reset", {7'd0, sdo_oe}, 8'h00);
    endtask

    task automatic test_rw;
        wr(4'd0, 3'd1, 8'hA5);
        chk("R3 write global reg1", cfg_global[15:8], 8'hA5);
        xfer(mk(1'b1, 4'd0, 3'd1), 8'h00, 16, 8'h00, rd, oe_ok);
        chk("R4 R2 read global reg1", rd, 8'hA5);
        chk("R5 oe window on read", {7'd0, oe_ok}, 8'h01);
        wr(4'd1, 3'd2, 8'h3C);
        chk("R12 port reg2 on cfg_port", cfg_port[23:16], 8'h3C);
        xfer(mk(1'b1, 4'd1, 3'd2), 8'h00, 16, 8'h00, rd, oe_ok);
        chk("R4 read port reg2", rd, 8'h3C);
        chk("R5 oe window port read", {7'd0, oe_ok}, 8'h01);
    endtask

    task automatic test_invalid_pa;
        wr(4'd2, 3'd2, 8'hFF);
        chk("R6 invalid port write ignored (port)", cfg_port[23:16], 8'h3C);
        chk("R6 invalid port write ignored (global)", cfg_global[23:16], 8'h00);
        xfer(mk(1'b1, 4'd3, 3'd1), 8'h00, 16, 8'h00, rd, oe_ok);
        chk("R6 invalid read keeps oe low", {7'd0, oe_ok}, 8'h01);
    endtask

    task automatic test_deselect;
        logic seen;
        seen = 1'b0;
        sen = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk) sdi = ~sdi; sclk = 1'b1;
            idle(HALF);
            sclk = 1'b0;
            idle(HALF);
            if (sdo_oe) seen = 1'b1;
        end
        sdi = 1'b0;
        chk("R1 no change while deselected", cfg_global[15:8], 8'hA5);
        chk("R1 oe low while deselected", {7'd0, seen}, 8'h00);
    endtask

    task automatic test_abort;
        xfer(mk(1'b0, 4'd0, 3'd1), 8'h11, 15, 8'h00, rd, oe_ok);
        chk("R11 short write ignored", cfg_global[15:8], 8'hA5);
        pulse_evt(8'h02);
        xfer(mk(1'b1, 4'd1, 3'd5), 8'h00, 12, 8'h00, rd, oe_ok);
        chk("R11 short status read keeps bits", cfg_port[47:40], 8'h02);
    endtask

    task automatic test_status;
        pulse_evt(8'hFF);
        chk("R9 masked events set", cfg_port[47:40], 8'h13);
        xfer(mk(1'b1, 4'd1, 3'd5), 8'h00, 16, 8'h00, rd, oe_ok);
        chk("R9 status read value", rd, 8'h13);
        chk("R9 status cleared by read", cfg_port[47:40], 8'h00);
        wr(4'd1, 3'd5, 8'hFF);
        chk("R12 status write ignored", cfg_port[47:40], 8'h00);
        wr(4'd1, 3'd6, 8'h5A);
        xfer(mk(1'b1, 4'd1, 3'd6), 8'h00, 16, 8'h00, rd, oe_ok);
        chk("R12 port reg6 reads zero", rd, 8'h00);
    endtask

    task automatic test_collision;
        pulse_evt(8'h01);
        xfer(mk(1'b1, 4'd1, 3'd5), 8'h00, 16, 8'h01, rd, oe_ok);
        chk("R10 read before collision", rd, 8'h01);
        chk("R10 event kept on clearing read", cfg_port[47:40], 8'h01);
        xfer(mk(1'b1, 4'd1, 3'd5), 8'h00, 16, 8'h00, rd, oe_ok);
        chk("R10 kept bit reads back", rd, 8'h01);
        chk("R9 cleared after plain read", cfg_port[47:40], 8'h00);
    endtask

    task automatic test_soft_reset;
        strap_refclk = 2'b11;
        wr(4'd0, 3'd0, 8'h18);
        chk("R7 ctrl write without reset", cfg_global[7:0], 8'h18);
        xfer(mk(1'b0, 4'd0, 3'd0), 8'h09, 16, 8'h02, rd, oe_ok);
        chk("R7 R8 soft reset ctrl default", cfg_global[7:0], 8'h10);
        chk("R7 soft reset global reg1", cfg_global[15:8], 8'h27);
        chk("R7 soft reset port reg2", cfg_port[23:16], 8'h00);
        chk("R10 event kept over soft reset", cfg_port[47:40], 8'h02);
        xfer(mk(1'b1, 4'd0, 3'd0), 8'h00, 16, 8'h00, rd, oe_ok);
        chk("R7 reset bit reads zero", rd, 8'h10);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(3);
        test_reset;
        test_rw;
        test_invalid_pa;
        test_deselect;
        test_abort;
        test_status;
        test_collision;
        test_soft_reset;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule